// File: doc/BRIEF.md
# Interval Timer with Read-Cleared Interrupts

A memory-mapped timer peripheral built around a 16-bit up-counter. The count advances on ticks from a prescaler whose divisor is a power of two. In interval mode the count climbs to a programmed limit, returns to zero on the following tick and raises a pending flag. Without interval mode it free-runs and wraps after 0xFFFF, raising a separate flag. Pending flags are masked by an enable register onto a registered, level-sensitive IRQ line.

Software starts a periodic interrupt by programming the divider, the limit and the enable mask, then clearing the hold bit. A handler reads the live count to time-stamp how long after the wrap it is running. Reading the status register both reports and clears the pending flags, which drops the IRQ. A flag raised in the same cycle as that read is kept, so no event is lost.

Top module: `ivl_timer`

## Requirements
- R1: After the synchronous active-high reset every register reads zero except counter control, which reads 0x0001 (held). The count is 0 and `irq` is low.
- R2: Clock control (offset 0x00) holds a divider enable in bit 0 and a select N in bits [4:1]. With bit 0 set the count advances once every 2^(N+1) clocks, so N=1 divides by 4. With bit 0 clear it advances every clock. Reads return bits [4:0].
- R3: Counter control (offset 0x0C) bit 0 set holds the count and the divider phase, and bit 0 clear lets them run. Bit 1 set selects interval mode. Reads return bits [1:0].
- R4: In interval mode, a tick that finds the count equal to the limit (offset 0x24, 16 bits) loads zero and sets status bit 0.
- R5: A tick that finds the count at 0xFFFF, with no interval match, loads zero and sets status bit 4.
- R6: Offset 0x18 reads the current count without changing it. Writes to it have no effect.
- R7: Reading status (offset 0x54) returns the pending flags in bits 0 and 4 and clears them. Writes to status have no effect.
- R8: A flag event in the same cycle as a status read leaves that flag set after the read.
- R9: `irq` is the OR of the status flags ANDed with enable bits 0 and 4 (offset 0x60), registered, so it rises one clock after a flag sets. Enable reads return only bits 0 and 4.
- R10: A write to counter control while the counter is held sets the count and the divider phase to zero.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_re` and holds until the next read. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong divider phase or a wrong count is visible at the next read of offset 0x18. It also shifts the cycle in which `irq` rises, which the bench compares every clock. A status flag that is lost or cleared wrongly shows up one clock later on `irq`, and at the next status read. A mismatch therefore surfaces within one interval period, or within a single clock when the interrupt is enabled.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int CNT_W  = 16;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int NEV    = 2;

  localparam logic [ADDR_W-1:0] OFF_CLK  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_LIM  = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_EN   = 8'h60;

  localparam int BIT_IV = 0;
  localparam int BIT_OV = 4;

  typedef enum int {EV_IV = 0, EV_OV = 1} ev_idx_e;
endpackage

// File: rtl/ivl_prescaler.sv
module ivl_prescaler #(
  parameter int SEL_W = ivl_timer_pkg::SEL_W,
  parameter int PH_W  = 2 ** SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic             pre_en,
  input  logic [SEL_W-1:0] pre_sel,
  output logic             tick
);
  function automatic logic [PH_W-1:0] last_phase(input logic [SEL_W-1:0] sel);
    logic [SEL_W:0] sh;
    sh = {1'b0, sel} + 1'b1;
    return ~({PH_W{1'b1}} << sh);
  endfunction

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_last;

  always_comb begin
    phase_last = last_phase(pre_sel);
    tick = run && (!pre_en || (phase_q == phase_last));
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else if (!run) begin
      if (clear) phase_q <= '0;
    end else if (!pre_en || tick) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  // R2: the divided tick never fires two cycles in a row
  a_r2_divided_tick: assert property (@(posedge clk) disable iff (rst)
    (tick && pre_en) |=> (!tick || !pre_en));
endmodule

// File: rtl/ivl_counter.sv
module ivl_counter #(
  parameter int CNT_W = ivl_timer_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             clear,
  input  logic             imode,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             ev_interval,
  output logic             ev_overflow
);
  logic [CNT_W-1:0] count_q;
  logic at_limit, at_top;

  always_comb begin
    at_limit    = imode && (count_q == limit);
    at_top      = (count_q == {CNT_W{1'b1}});
    ev_interval = tick && at_limit;
    ev_overflow = tick && !at_limit && at_top;
    count       = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) count_q <= '0;
    else if (tick) count_q <= (at_limit || at_top) ? '0 : count_q + 1'b1;
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(count_q));
  a_r4_interval_wrap: assert property (@(posedge clk) disable iff (rst)
    ev_interval |=> (count_q == '0));
  a_r5_top_wrap: assert property (@(posedge clk) disable iff (rst)
    ev_overflow |=> (count_q == '0));
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count_q == '0));
endmodule

// File: rtl/ivl_irq_ctrl.sv
module ivl_irq_ctrl #(
  parameter int NEV = ivl_timer_pkg::NEV
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev,
  input  logic           rd_clr,
  input  logic [NEV-1:0] en,
  output logic [NEV-1:0] flags,
  output logic           irq
);
  logic [NEV-1:0] flags_q;
  logic           irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~{NEV{rd_clr}}) | ev;
      irq_q   <= |(flags_q & en);
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

  for (genvar i = 0; i < NEV; i++) begin : g_chk
    a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> flags_q[i]);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && !ev[i]) |=> !flags_q[i]);
  end

  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (|(flags_q & en)) |=> irq_q);
  a_r9_irq_fall: assert property (@(posedge clk) disable iff (rst)
    !(|(flags_q & en)) |=> !irq_q);
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int SW = SEL_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int CLK_W = SW + 1;

  logic [CLK_W-1:0] clk_q;
  logic [1:0]       ctl_q;
  logic [CW-1:0]    lim_q;
  logic [NEV-1:0]   en_q;
  logic [DW-1:0]    rdata_q;

  logic wr_clk, wr_ctl, wr_lim, wr_en, rd_stat;
  logic run, clear, tick;
  logic [CW-1:0]  count;
  logic [NEV-1:0] ev, flags;

  always_comb begin
    wr_clk  = bus_we && (bus_addr == OFF_CLK);
    wr_ctl  = bus_we && (bus_addr == OFF_CTL);
    wr_lim  = bus_we && (bus_addr == OFF_LIM);
    wr_en   = bus_we && (bus_addr == OFF_EN);
    rd_stat = bus_re && (bus_addr == OFF_STAT);
    run     = !ctl_q[0];
    clear   = wr_ctl && ctl_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= '0;
      ctl_q <= 2'b01;
      lim_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_clk) clk_q <= bus_wdata[CLK_W-1:0];
      if (wr_ctl) ctl_q <= bus_wdata[1:0];
      if (wr_lim) lim_q <= bus_wdata[CW-1:0];
      if (wr_en)  en_q  <= {bus_wdata[BIT_OV], bus_wdata[BIT_IV]};
    end
  end

  ivl_prescaler #(.SEL_W(SW)) u_pre (
    .clk(clk), .rst(rst), .run(run), .clear(clear),
    .pre_en(clk_q[0]), .pre_sel(clk_q[CLK_W-1:1]), .tick(tick)
  );

  ivl_counter #(.CNT_W(CW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .clear(clear),
    .imode(ctl_q[1]), .limit(lim_q), .count(count),
    .ev_interval(ev[EV_IV]), .ev_overflow(ev[EV_OV])
  );

  ivl_irq_ctrl #(.NEV(NEV)) u_irq (
    .clk(clk), .rst(rst), .ev(ev), .rd_clr(rd_stat),
    .en(en_q), .flags(flags), .irq(irq)
  );

  function automatic logic [DW-1:0] place_bits(input logic [NEV-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[BIT_IV] = v[EV_IV];
    r[BIT_OV] = v[EV_OV];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_re) begin
      case (bus_addr)
        OFF_CLK:  rdata_q <= DW'(clk_q);
        OFF_CTL:  rdata_q <= DW'(ctl_q);
        OFF_CNT:  rdata_q <= DW'(count);
        OFF_LIM:  rdata_q <= DW'(lim_q);
        OFF_STAT: rdata_q <= place_bits(flags);
        OFF_EN:   rdata_q <= place_bits(en_q);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

  a_r11_read_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(rdata_q));
endmodule

// File: tb/tb_ivl_timer.sv
`timescale 1ns/1ps
module tb_ivl_timer;
  logic clk = 0, rst = 1;
  logic [7:0]  bus_addr = 0;
  logic        bus_we = 0, bus_re = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  ivl_timer dut (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq(irq));

  int n_cmp = 0, n_bad = 0;
  string tag = "";

  // reference state
  logic [4:0]  m_clk;  logic [1:0] m_ctl;  logic [15:0] m_lim;
  logic [15:0] m_en, m_st, m_cnt, m_ph, m_rd;
  logic m_irq, m_rv;
  logic [7:0] m_ra;

  function automatic logic [15:0] div_last(input logic [3:0] n);
    int d = 1 << (n + 1);
    return 16'((d - 1) & 32'hFFFF);
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R2"; 8'h0C: return "R3"; 8'h18: return "R6";
      8'h24: return "R4"; 8'h54: return "R7/R8"; 8'h60: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    m_clk = 0; m_ctl = 2'b01; m_lim = 0; m_en = 0; m_st = 0; m_cnt = 0;
    m_ph = 0; m_rd = 0; m_irq = 0; m_rv = 0; m_ra = 0;
  endtask

  function automatic bit iv_next();
    bit t;
    t = !m_ctl[0] && (!m_clk[0] || m_ph == div_last(m_clk[4:1]));
    return t && m_ctl[1] && m_cnt == m_lim;
  endfunction

  task automatic model_step(input logic [7:0] a, input bit we, input logic [15:0] wd, input bit re);
    bit held, t, ctlw;
    logic [15:0] ev, nst;
    held = m_ctl[0]; ctlw = we && a == 8'h0C; ev = 0;
    t = !held && (!m_clk[0] || m_ph == div_last(m_clk[4:1]));
    if (re) begin
      m_rv = 1; m_ra = a;
      m_rd = (a == 8'h00) ? {11'd0, m_clk} : (a == 8'h0C) ? {14'd0, m_ctl} :
             (a == 8'h18) ? m_cnt : (a == 8'h24) ? m_lim :
             (a == 8'h54) ? m_st : (a == 8'h60) ? m_en : 16'd0;
    end else m_rv = 0;
    nst = (re && a == 8'h54) ? 16'd0 : m_st;
    m_irq = |(m_st & m_en);
    if (held) begin
      if (ctlw) begin m_ph = 0; m_cnt = 0; end
    end else begin
      m_ph = (t || !m_clk[0]) ? 16'd0 : m_ph + 1;
      if (t) begin
        if (m_ctl[1] && m_cnt == m_lim) begin m_cnt = 0; ev[0] = 1; end
        else if (m_cnt == 16'hFFFF) begin m_cnt = 0; ev[4] = 1; end
        else m_cnt = m_cnt + 1;
      end
    end
    m_st = nst | ev;
    if (we) case (a)
      8'h00: m_clk = wd[4:0];
      8'h0C: m_ctl = wd[1:0];
      8'h24: m_lim = wd;
      8'h60: m_en  = wd & 16'h0011;
      default: ;
    endcase
  endtask

  task automatic compare();
    string t;
    n_cmp++;
    if (irq !== m_irq) begin
      n_bad++;
      $display("FAIL %s irq: actual %0b expected %0b", (tag != "") ? tag : "R9", irq, m_irq);
    end
    if (m_rv) begin
      t = (tag != "") ? tag : tag_of(m_ra);
      n_cmp++;
      if (bus_rdata !== m_rd) begin
        n_bad++;
        $display("FAIL %s read @%02h: actual %04h expected %04h", t, m_ra, bus_rdata, m_rd);
      end
    end
  endtask

  // runs at a negedge: drive, advance model, wait one clock, compare
  task automatic op(input logic [7:0] a, input bit we, input logic [15:0] wd, input bit re);
    bus_addr = a; bus_we = we; bus_wdata = wd; bus_re = re;
    model_step(a, we, wd, re);
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d); op(a, 1, d, 0); endtask
  task automatic rd(input logic [7:0] a); op(a, 0, 0, 1); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) op(8'h04, 0, 0, 0); endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [7] = '{8'h00, 8'h0C, 8'h18, 8'h24, 8'h54, 8'h60, 8'h04};
    int seed_dummy;
    seed_dummy = $urandom(32'h1234);
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    tag = "R1";
    foreach (addrs[i]) rd(addrs[i]);
    // R11 unmapped
    tag = "R11"; rd(8'h44); idle(2);
    tag = "";
    // R2/R4/R9: divide by 4, limit 5, interval interrupt
    wr(8'h00, 16'h0003); wr(8'h24, 16'd5); wr(8'h60, 16'h0011); wr(8'h0C, 16'h0002);
    for (int i = 0; i < 40; i++) rd(8'h18);
    rd(8'h54); rd(8'h54); idle(30);
    // R8: status read coincides with interval event
    tag = "R8";
    for (int i = 0; i < 200 && !iv_next(); i++) idle(1);
    rd(8'h54); rd(8'h54); idle(2);
    // R6/R7 writes ignored
    tag = "R6"; wr(8'h18, 16'hBEEF); rd(8'h18);
    tag = "R7"; wr(8'h54, 16'hFFFF); rd(8'h54);
    // R3 hold, R10 clear while held
    tag = "R3"; wr(8'h0C, 16'h0001); rd(8'h18); idle(10); rd(8'h18);
    tag = "R10"; wr(8'h0C, 16'h0003); rd(8'h18); idle(5); rd(8'h18);
    // R5 free-run wrap at 0xFFFF, no divider
    tag = "R5";
    wr(8'h00, 16'h0000); wr(8'h60, 16'h0010); wr(8'h0C, 16'h0000);
    idle(65530); rd(8'h18); idle(10); rd(8'h54); idle(3);
    // R2 large divider select
    tag = "R2"; wr(8'h0C, 16'h0001); wr(8'h0C, 16'h0001);
    wr(8'h00, 16'h0009); wr(8'h0C, 16'h0000);
    for (int i = 0; i < 20; i++) begin idle(15); rd(8'h18); end
    tag = "";
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] a; logic [15:0] d; int k;
      a = addrs[$urandom % 7];
      k = $urandom % 8;
      d = 16'($urandom);
      if (a == 8'h00) d = {11'd0, 2'b00, d[1:0], d[0]};
      if (a == 8'h24) d = 16'($urandom % 24);
      if (a == 8'h0C) d = {14'd0, d[1], (k == 0)};
      if (k < 2) op(a, 1, d, 0);
      else if (k < 5) op(a, 0, 0, 1);
      else if (k == 5) op(a, 1, d, 1);
      else idle(1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule